// File: doc/BRIEF.md
# SHA-256 Compression Round Engine

This block performs the SHA-256 compression function on a stream of already expanded message-schedule words. It applies one round for each accepted word, so a block of 64 words is taken in over 64 consecutive cycles when the source keeps up. After the last word of a block, the engine spends one cycle adding the working variables into the chaining state. That state then carries into the next block of the same message. When the block that closes a message has been folded, the 256-bit digest is presented on an output stream.

Padding and schedule expansion happen upstream. The producer sends exactly 64 words per block and flags the 64th word as the end of its block. On that same word it also flags whether the block ends the message. Both streams use valid/ready. A word transfers on a clock edge where `in_valid` and `in_ready` are both high. While `in_valid` is low, the round counter and the working variables hold. The engine lowers `in_ready` in two cases: during the fold cycle, and for as long as a digest is waiting. The digest transfers on an edge where `out_valid` and `out_ready` are both high. Until then it stays unchanged. After the transfer, the chaining state returns to the standard initial words, ready for the next message.

Top module: `sha256_round_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Each accepted word performs one round on working variables a..h. The round computes T1 = h + S1(e) + Ch(e,f,g) + K[t] + W and T2 = S0(a) + Maj(a,b,c). Then a gets T1+T2, e gets d+T1, and b,c,d,f,g,h take the old a,b,c,e,f,g. The functions are S0 = rotr2^rotr13^rotr22, S1 = rotr6^rotr11^rotr25, Ch = (e&f)^(~e&g), and Maj is the bitwise majority. K[t] is the first 32 fractional bits of the cube root of the (t+1)-th prime, where t is the word's position in its block (0..63).
- R3: On the first word of a block, the round starts from the chaining state rather than from the working registers. A block is 64 words, and its 64th word carries `in_blk_last`. The edge after that word is a fold cycle with `in_ready` low, in which each working variable is added modulo 2^32 into its chaining word.
- R4: At reset, and after each digest transfer, the chaining state equals the eight initial words. Each initial word is the first 32 fractional bits of the square root of one of the first eight primes.
- R5: If `in_msg_last` was high on a block's last word, `out_valid` rises in the cycle after the fold. `out_digest` carries chaining word 0 in bits 255:224, down to word 7 in bits 31:0.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_digest` hold and `in_ready` is low. Words offered in that time are not consumed.
- R7: A cycle with `in_valid` low advances no round. The value on `in_word` in that cycle has no effect on any digest.
- R8: If `in_msg_last` is low on a block's last word, no digest is produced. `in_ready` returns high in the cycle after the fold, and the next block chains from the folded state.
- R9: With `in_valid` held high, all 64 words of a block are accepted on 64 consecutive edges (one round per cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Schedule word offered |
| in_ready | output | 1 | Engine can take a word this cycle |
| in_word | input | 32 | Schedule word W[t] |
| in_blk_last | input | 1 | Word is the 64th of its block |
| in_msg_last | input | 1 | With `in_blk_last`: the block ends the message |
| out_valid | output | 1 | Digest available |
| out_ready | input | 1 | Consumer takes the digest |
| out_digest | output | 256 | Digest, word 0 in the top bits |

## Verification
Two single-block known-answer messages (the empty string and "abc") pin down the round constants, the initial words and the output word order against values fixed outside both model and design. A two-block known-answer message separates correct chaining across a fold from restarting at the initial words. A run of pseudo-random messages of one to three blocks follows. These differ in input bubbles carrying junk words, in how long the digest is stalled, and in words offered while the digest waits. Any round that advances on an invalid cycle, or any state that leaks from one message into the next, shows up as a digest mismatch against the bench's arithmetic model. The cycle-exact checks around each block end set a fold that is one cycle too long or too short apart from a correct one.

// File: rtl/sha256_pkg.sv
package sha256_pkg;

  localparam int WORD_W     = 32;
  localparam int NUM_VARS   = 8;
  localparam int NUM_ROUNDS = 64;

  typedef logic [WORD_W-1:0] word_t;
  // index 0 is variable a / chaining word 0
  typedef logic [NUM_VARS-1:0][WORD_W-1:0] state_t;

  typedef enum logic [1:0] {
    ENG_RUN  = 2'd0,
    ENG_FOLD = 2'd1,
    ENG_OUT  = 2'd2
  } eng_state_e;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t choose(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t majority(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  function automatic word_t init_word(input int idx);
    case (idx)
      0: return 32'h6a09e667;
      1: return 32'hbb67ae85;
      2: return 32'h3c6ef372;
      3: return 32'ha54ff53a;
      4: return 32'h510e527f;
      5: return 32'h9b05688c;
      6: return 32'h1f83d9ab;
      default: return 32'h5be0cd19;
    endcase
  endfunction

  function automatic state_t init_state();
    state_t s;
    for (int i = 0; i < NUM_VARS; i++) s[i] = init_word(i);
    return s;
  endfunction

  function automatic word_t round_const(input logic [5:0] idx);
    case (idx)
      6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491;
      6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1;
      6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01;
      6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe;
      6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786;
      6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa;
      6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d;
      6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147;
      6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138;
      6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb;
      6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b;
      6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624;
      6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08;
      6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a;
      6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f;
      6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb;
      6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
    endcase
  endfunction

endpackage

// File: rtl/sha256_kconst.sv
module sha256_kconst
  import sha256_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  output word_t            k
);
  always_comb k = round_const(6'(idx));
endmodule

// File: rtl/sha256_round.sv
module sha256_round
  import sha256_pkg::*;
(
  input  state_t cur,
  input  word_t  w,
  input  word_t  k,
  output state_t nxt
);
  word_t t1, t2;

  always_comb begin
    t1 = cur[7] + big_s1(cur[4]) + choose(cur[4], cur[5], cur[6]) + k + w;
    t2 = big_s0(cur[0]) + majority(cur[0], cur[1], cur[2]);
    nxt[0] = t1 + t2;
    nxt[1] = cur[0];
    nxt[2] = cur[1];
    nxt[3] = cur[2];
    nxt[4] = cur[3] + t1;
    nxt[5] = cur[4];
    nxt[6] = cur[5];
    nxt[7] = cur[6];
  end
endmodule

// File: rtl/sha256_fold.sv
module sha256_fold
  import sha256_pkg::*;
#(
  parameter int LANES = NUM_VARS
) (
  input  state_t chain,
  input  state_t work,
  output state_t sum
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sum[i] = chain[i] + work[i];
  end
endmodule

// File: rtl/sha256_round_engine.sv
module sha256_round_engine
  import sha256_pkg::*;
#(
  parameter int ROUNDS = NUM_ROUNDS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [31:0]  in_word,
  input  logic         in_blk_last,
  input  logic         in_msg_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [255:0] out_digest
);
  localparam int CNT_W = $clog2(ROUNDS);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  eng_state_e       st_q;
  logic [CNT_W-1:0] rnd_q;
  state_t           hash_q, work_q;
  state_t           round_src, round_nxt, fold_sum;
  logic             msg_end_q;
  word_t            k_t;
  logic             take;

  assign in_ready  = (st_q == ENG_RUN);
  assign out_valid = (st_q == ENG_OUT);
  assign take      = in_valid && in_ready;

  // first round of a block starts from the chaining state
  assign round_src = (rnd_q == '0) ? hash_q : work_q;

  sha256_kconst #(.IDX_W(CNT_W)) u_kconst (
    .idx (rnd_q),
    .k   (k_t)
  );

  sha256_round u_round (
    .cur (round_src),
    .w   (in_word),
    .k   (k_t),
    .nxt (round_nxt)
  );

  sha256_fold #(.LANES(NUM_VARS)) u_fold (
    .chain (hash_q),
    .work  (work_q),
    .sum   (fold_sum)
  );

  for (genvar i = 0; i < NUM_VARS; i++) begin : g_pack
    assign out_digest[WORD_W*(NUM_VARS-i)-1 -: WORD_W] = hash_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ENG_RUN;
      rnd_q     <= '0;
      hash_q    <= init_state();
      work_q    <= '0;
      msg_end_q <= 1'b0;
    end else begin
      case (st_q)
        ENG_RUN: begin
          if (take) begin
            work_q <= round_nxt;
            if (in_blk_last) begin
              rnd_q     <= '0;
              msg_end_q <= in_msg_last;
              st_q      <= ENG_FOLD;
            end else begin
              rnd_q <= rnd_q + CNT_ONE;
            end
          end
        end
        ENG_FOLD: begin
          hash_q <= fold_sum;
          st_q   <= msg_end_q ? ENG_OUT : ENG_RUN;
        end
        ENG_OUT: begin
          if (out_ready) begin
            hash_q <= init_state();
            st_q   <= ENG_RUN;
          end
        end
        default: st_q <= ENG_RUN;
      endcase
    end
  end
endmodule

// File: rtl/sha256_round_engine_chk.sv
module sha256_round_engine_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_blk_last,
  input logic             in_msg_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic [255:0]     out_digest,
  input logic [CNT_W-1:0] rnd
);
  localparam logic [CNT_W-1:0] LAST_IDX = {CNT_W{1'b1}};

  logic acc, acc_last;
  assign acc      = in_valid && in_ready;
  assign acc_last = acc && in_blk_last;

  // R1: idle after reset
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (!out_valid && in_ready));

  // R3: block end flag only on the 64th word
  p_blk_len_r3: assert property (@(posedge clk) disable iff (!rst_n) acc_last |-> rnd == LAST_IDX);

  // R3: fold cycle refuses input
  p_fold_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n) acc_last |=> !in_ready && !out_valid);

  // R8: mid-message block resumes after one fold cycle
  p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_last && !in_msg_last) |=> ##1 (in_ready && !out_valid));

  // R5: digest appears in the cycle after the fold
  p_digest_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_last && in_msg_last) |=> ##1 out_valid);

  // R5: no digest without a closing block
  p_digest_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc_last && in_msg_last, 2));

  // R6: held digest is stable
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_digest)));

  // R6: no input taken while a digest waits
  p_out_blocks_in_r6: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !in_ready);

  // R7: a bubble does not drop readiness
  p_bubble_keeps_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  // R9: mid-block acceptance keeps readiness
  p_stream_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_blk_last) |=> in_ready);
endmodule

bind sha256_round_engine sha256_round_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_blk_last (in_blk_last),
  .in_msg_last (in_msg_last),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_digest  (out_digest),
  .rnd         (rnd_q)
);

// File: tb/sha256_round_engine_test.sv
`timescale 1ns/1ps
module sha256_round_engine_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_word = '0;
  logic         in_blk_last = 1'b0;
  logic         in_msg_last = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [255:0] out_digest;

  int checks = 0;
  int fails  = 0;

  logic [31:0]  kt [64];
  logic [31:0]  ivt [8];
  logic [31:0]  blk_w [16];
  logic [31:0]  sch [64];
  logic [255:0] ref_h;
  logic [31:0]  lfsr = 32'h1234_5678;
  int           rate_miss;

  always #2 clk = ~clk;

  sha256_round_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_blk_last(in_blk_last), .in_msg_last(in_msg_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_digest(out_digest)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] frac_root(input int p, input int deg);
    logic [127:0] tgt, lo, hi, mid, pw;
    tgt = (deg == 2) ? (128'(p) << 64) : (128'(p) << 96);
    lo = '0;
    hi = 128'h1 << 40;
    while (hi - lo > 1) begin
      mid = (lo + hi) >> 1;
      pw  = (deg == 2) ? mid * mid : mid * mid * mid;
      if (pw <= tgt) lo = mid; else hi = mid;
    end
    return lo[31:0];
  endfunction

  task automatic build_consts();
    int cnt = 0;
    for (int n = 2; cnt < 64; n++) begin
      bit isp = 1'b1;
      for (int d = 2; d * d <= n; d++) if (n % d == 0) isp = 1'b0;
      if (isp) begin
        kt[cnt] = frac_root(n, 3);
        if (cnt < 8) ivt[cnt] = frac_root(n, 2);
        cnt++;
      end
    end
  endtask

  function automatic logic [255:0] iv_vec();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[255 - 32*i -: 32] = ivt[i];
    return v;
  endfunction

  task automatic expand();
    for (int t = 0; t < 64; t++) begin
      if (t < 16) sch[t] = blk_w[t];
      else sch[t] = (rr(sch[t-2], 17) ^ rr(sch[t-2], 19) ^ (sch[t-2] >> 10)) + sch[t-7]
                  + (rr(sch[t-15], 7) ^ rr(sch[t-15], 18) ^ (sch[t-15] >> 3)) + sch[t-16];
    end
  endtask

  // reference compression of sch[] on ref_h
  task automatic ref_block();
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    for (int i = 0; i < 8; i++) v[i] = ref_h[255 - 32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25)) + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kt[t] + sch[t];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22)) + ((v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) ref_h[255 - 32*i -: 32] = ref_h[255 - 32*i -: 32] + v[i];
  endtask

  function automatic logic [31:0] rnd32();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // send sch[] as one block; gap>0 inserts bubbles with junk words
  task automatic send_block(input bit last_msg, input int gap);
    for (int t = 0; t < 64; t++) begin
      if (gap > 0 && (t % 7) == 3) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0; in_word = rnd32();   // R7 junk during bubble
          in_blk_last = 1'b1; in_msg_last = 1'b1;
        end
      end
      @(negedge clk);
      if (!in_ready) rate_miss++;
      in_valid = 1'b1; in_word = sch[t];
      in_blk_last = (t == 63); in_msg_last = last_msg && (t == 63);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_blk_last = 1'b0; in_msg_last = 1'b0;
    check("R3 fold cycle in_ready", {255'd0, in_ready}, 256'd0);
    check("R3 fold cycle out_valid", {255'd0, out_valid}, 256'd0);
    @(negedge clk);
    if (last_msg) begin
      check("R5 out_valid after fold", {255'd0, out_valid}, 256'd1);
    end else begin
      check("R8 ready after fold", {255'd0, in_ready}, 256'd1);
      check("R8 no digest mid-message", {255'd0, out_valid}, 256'd0);
    end
  endtask

  // digest at out; stall cycles with junk offered, then take it
  task automatic take_digest(input int stall, input logic [255:0] exp, input string req);
    logic [255:0] first;
    first = out_digest;
    check(req, out_digest, exp);
    for (int s = 0; s < stall; s++) begin
      in_valid = 1'b1; in_word = rnd32(); in_blk_last = 1'b1; in_msg_last = 1'b1;
      @(negedge clk);
      check("R6 digest held", out_digest, first);
      check("R6 valid held, input blocked", {254'd0, out_valid, in_ready}, {254'd0, 2'b10});
    end
    in_valid = 1'b0; in_blk_last = 1'b0; in_msg_last = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R4 idle after digest taken", {254'd0, out_valid, in_ready}, {254'd0, 2'b01});
  endtask

  task automatic zero_blk();
    for (int i = 0; i < 16; i++) blk_w[i] = '0;
  endtask

  initial begin
    build_consts();
    #1;
    check("R1 in reset", {254'd0, out_valid, in_ready}, {254'd0, 2'b01});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {254'd0, out_valid, in_ready}, {254'd0, 2'b01});

    // R2 R4 R5 known answer: empty message
    zero_blk(); blk_w[0] = 32'h8000_0000;
    expand(); ref_h = iv_vec(); ref_block();
    check("R2 model empty", ref_h, 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855);
    send_block(1'b1, 0);
    take_digest(0, 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855, "R2 empty digest");

    // known answer: "abc", with output stall
    zero_blk(); blk_w[0] = 32'h6162_6380; blk_w[15] = 32'h18;
    expand();
    rate_miss = 0;
    send_block(1'b1, 0);
    check("R9 one word per cycle", 256'(rate_miss), 256'd0);
    take_digest(3, 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad, "R4 R5 abc digest");

    // R8 two-block known answer
    for (int i = 0; i < 14; i++) blk_w[i] = 32'h6162_6364 + i * 32'h0101_0101;
    blk_w[14] = 32'h8000_0000; blk_w[15] = '0;
    expand(); send_block(1'b0, 0);
    zero_blk(); blk_w[15] = 32'h1c0;
    expand(); send_block(1'b1, 0);
    take_digest(1, 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1, "R8 two-block digest");

    // pseudo-random messages: varied block count, bubbles, stalls
    for (int m = 0; m < 9; m++) begin
      int nb = 1 + (m % 3);
      ref_h = iv_vec();
      for (int b = 0; b < nb; b++) begin
        for (int i = 0; i < 16; i++) blk_w[i] = rnd32();
        expand(); ref_block();
        send_block(b == nb - 1, (m % 2 == 1) ? 1 + (m % 3) : 0);
      end
      take_digest(m % 4, ref_h, "R2 R7 random message digest");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule